// File: doc/BRIEF.md
# Input Capture First-Edge Polarity Status

This block keeps one status bit per timer input channel. The bit records whether the capture-causing edge that came first after the channel's capture latch was last read was rising or falling. Each channel has an asynchronous input pin, a two-bit edge-mode setting and a one-cycle latch-read strobe. The pin is resynchronised, and its edges are compared against the edge mode. The first edge that qualifies while the channel is armed sets the channel's bit and disarms the channel.

Edges that arrive while a channel is disarmed leave its bit as it is. A latch-read strobe arms the channel again. The bits are outputs only. Bit k of `pol_o` belongs to channel k, so with four channels the bits fill positions 3 down to 0 of the status word that surrounding logic builds.

Top module: `fpol_status`

## Requirements
- R1: After reset every polarity bit is 0 and every channel is armed, so the first qualifying edge after reset is recorded.
- R2: A qualifying rising edge on an armed channel sets that channel's bit to 1.
- R3: A qualifying falling edge on an armed channel sets that channel's bit to 0.
- R4: Once a channel has recorded an edge it is disarmed, and later edges leave its bit unchanged until the next latch-read strobe.
- R5: A latch-read strobe (`rd_i[k]` high for one cycle) re-arms channel k, so its next qualifying edge updates the bit.
- R6: Edge mode 2'b00 disables a channel: no edge changes its bit or disarms it.
- R7: Edge mode 2'b01 qualifies only rising edges, 2'b10 only falling edges and 2'b11 both. The mode of channel k sits in `mode_i[2k+1:2k]`.
- R8: If a qualifying edge and a latch-read strobe meet in the same cycle on an armed channel, the edge is recorded and the channel stays disarmed.
- R9: Each pin passes two synchroniser flops before edge detection. A pin change applied before clock edge n shows on `pol_o` after clock edge n+2 and not before.
- R10: Channels are independent. Edges, modes and strobes of one channel never alter another channel's bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| pin_i | input | NUM_CH | Asynchronous timer input pins, one per channel |
| mode_i | input | 2*NUM_CH | Edge mode per channel, two bits each |
| rd_i | input | NUM_CH | Capture-latch-read strobe per channel |
| pol_o | output | NUM_CH | First-edge polarity bit per channel (1 rising, 0 falling) |

## Verification
The bench builds the block with its defaults: four channels and a two-stage synchroniser. Four channels give enough room to keep each channel in a different edge mode while another channel takes edges, and to drive edges on an armed and a disarmed channel in the same cycle. The two-stage depth fixes the capture at exactly three clock edges after the pin change. This lets the bench place a latch-read strobe precisely on the qualifying cycle to exercise the collision rule, and check that the bit does not move one cycle early.

// File: rtl/fpol_pkg.sv
package fpol_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 2'b00,
        MODE_RISE = 2'b01,
        MODE_FALL = 2'b10,
        MODE_BOTH = 2'b11
    } pol_mode_e;

    typedef struct packed {
        logic prev;
    } edge_state_t;

    typedef struct packed {
        logic armed;
        logic pol;
    } chan_state_t;

endpackage

// File: rtl/fpol_sync.sv
module fpol_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb begin
                sh_d = {sh_q[STAGES-2:0], d_i};
            end
        end else begin : g_single
            always_comb begin
                sh_d = d_i;
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/fpol_edge.sv
module fpol_edge
    import fpol_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      lvl_i,
    input  pol_mode_e mode_i,
    output logic      hit_o,
    output logic      rise_o
);
    edge_state_t st_d, st_q;
    logic up, down;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        up        = lvl_i & ~st_q.prev;
        down      = ~lvl_i & st_q.prev;
        unique case (mode_i)
            MODE_RISE: hit_o = up;
            MODE_FALL: hit_o = down;
            MODE_BOTH: hit_o = up | down;
            default:   hit_o = 1'b0;
        endcase
        rise_o = up;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_OFF) |-> !hit_o); // R6
    AST_FALL_MODE_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_FALL && hit_o) |-> !rise_o); // R7
endmodule

// File: rtl/fpol_chan.sv
module fpol_chan
    import fpol_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic rise_i,
    input  logic rd_i,
    output logic pol_o
);
    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.armed && hit_i) begin
            st_d.pol   = rise_i;
            st_d.armed = 1'b0;
        end else if (rd_i) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{armed: 1'b1, pol: 1'b0};
        else         st_q <= st_d;
    end

    assign pol_o = st_q.pol;

    AST_CAPTURE_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.armed && hit_i) |=> (pol_o == $past(rise_i))); // R2
    AST_HOLD_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.armed |=> $stable(pol_o)); // R4
    AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !(st_q.armed && hit_i)) |=> st_q.armed); // R5
    AST_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && hit_i && st_q.armed) |=> !st_q.armed); // R8
endmodule

// File: rtl/fpol_status.sv
module fpol_status
    import fpol_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_CH-1:0]        pin_i,
    input  logic [NUM_CH*MODE_W-1:0] mode_i,
    input  logic [NUM_CH-1:0]        rd_i,
    output logic [NUM_CH-1:0]        pol_o
);
    localparam int CAP_LAT = SYNC_STAGES + 1;

    logic [NUM_CH-1:0] lvl, hit, rise;

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            fpol_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk_i (clk_i),
                .rst_ni(rst_ni),
                .d_i   (pin_i[k]),
                .q_o   (lvl[k])
            );

            fpol_edge u_edge (
                .clk_i (clk_i),
                .rst_ni(rst_ni),
                .lvl_i (lvl[k]),
                .mode_i(pol_mode_e'(mode_i[k*MODE_W +: MODE_W])),
                .hit_o (hit[k]),
                .rise_o(rise[k])
            );

            fpol_chan u_chan (
                .clk_i (clk_i),
                .rst_ni(rst_ni),
                .hit_i (hit[k]),
                .rise_i(rise[k]),
                .rd_i  (rd_i[k]),
                .pol_o (pol_o[k])
            );

            if (CAP_LAT == 3) begin : g_lat_chk
                AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    $rose(pol_o[k]) |-> $past(pin_i[k], 2)); // R9
            end
        end
    endgenerate
endmodule

// File: tb/fpol_status_test.sv
`timescale 1ns/1ps
module fpol_status_test;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin = '0;
    logic [2*NCH-1:0] mode = '0;
    logic [NCH-1:0] rd = '0;
    logic [NCH-1:0] pol;
    logic [NCH-1:0] exp_v = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fpol_status #(.NUM_CH(NCH), .SYNC_STAGES(2)) uut (
        .clk_i (clk),
        .rst_ni(rst_n),
        .pin_i (pin),
        .mode_i(mode),
        .rd_i  (rd),
        .pol_o (pol)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req);
        n_chk++;
        if (pol !== exp_v) begin
            n_bad++;
            $display("FAIL %s: pol=%b expected %b at %0t", req, pol, exp_v, $time);
        end
    endtask

    task automatic set_mode(input int ch, input logic [1:0] m);
        mode[2*ch +: 2] = m;
    endtask

    task automatic rd_pulse(input int ch);
        rd[ch] = 1'b1;
        wait_cyc(1);
        rd[ch] = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset value");
    endtask

    task automatic t_rise_latency;
        pin[0] = 1'b1;
        wait_cyc(2);
        chk("R9 no early update");
        wait_cyc(1);
        exp_v[0] = 1'b1;
        chk("R2 rising recorded");
    endtask

    task automatic t_first_only;
        pin[0] = 1'b0;
        wait_cyc(4);
        chk("R4 later falling ignored");
        pin[0] = 1'b1;
        wait_cyc(4);
        chk("R4 later rising ignored");
    endtask

    task automatic t_fall_rearm;
        rd_pulse(0);
        pin[0] = 1'b0;
        wait_cyc(4);
        exp_v[0] = 1'b0;
        chk("R3 falling recorded");
        rd_pulse(0);
        pin[0] = 1'b1;
        wait_cyc(4);
        exp_v[0] = 1'b1;
        chk("R5 re-armed by latch read");
    endtask

    task automatic t_mode_off;
        pin[1] = 1'b1;
        wait_cyc(4);
        chk("R6 off mode rising");
        pin[1] = 1'b0;
        wait_cyc(4);
        chk("R6 off mode falling");
        set_mode(1, 2'b01);
        pin[1] = 1'b1;
        wait_cyc(4);
        exp_v[1] = 1'b1;
        chk("R6 stayed armed while off, R7 rise mode");
    endtask

    task automatic t_mode_fall;
        pin[2] = 1'b1;
        wait_cyc(4);
        exp_v[2] = 1'b1;
        chk("R7 both mode rising");
        rd_pulse(2);
        set_mode(2, 2'b10);
        pin[2] = 1'b0;
        wait_cyc(4);
        exp_v[2] = 1'b0;
        chk("R7 fall mode falling");
        rd_pulse(2);
        pin[2] = 1'b1;
        wait_cyc(4);
        chk("R7 fall mode ignores rising");
        pin[2] = 1'b0;
        wait_cyc(4);
        chk("R7 fall mode second falling");
    endtask

    task automatic t_mode_rise;
        pin[3] = 1'b1;
        wait_cyc(4);
        exp_v[3] = 1'b1;
        chk("R7 rise mode rising");
        rd_pulse(3);
        pin[3] = 1'b0;
        wait_cyc(4);
        chk("R7 rise mode ignores falling");
    endtask

    task automatic t_collide;
        set_mode(1, 2'b11);
        rd_pulse(1);
        pin[1] = 1'b0;
        wait_cyc(2);
        rd[1] = 1'b1;
        wait_cyc(1);
        rd[1] = 1'b0;
        exp_v[1] = 1'b0;
        chk("R8 edge wins over same-cycle read");
        pin[1] = 1'b1;
        wait_cyc(4);
        chk("R8 channel stays disarmed");
    endtask

    task automatic t_independent;
        rd_pulse(2);
        set_mode(2, 2'b11);
        pin[0] = 1'b0;
        pin[2] = 1'b1;
        wait_cyc(4);
        exp_v[2] = 1'b1;
        chk("R10 armed and disarmed channels together");
    endtask

    task automatic t_reset_again;
        pin = '0;
        wait_cyc(4);
        rst_n = 1'b0;
        wait_cyc(2);
        exp_v = '0;
        chk("R1 reset clears bits");
        rst_n = 1'b1;
        wait_cyc(4);
        pin[3] = 1'b1;
        wait_cyc(4);
        exp_v[3] = 1'b1;
        chk("R1 armed after reset");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        set_mode(0, 2'b11);
        set_mode(1, 2'b00);
        set_mode(2, 2'b11);
        set_mode(3, 2'b01);
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_rise_latency();
        t_first_only();
        t_fall_rearm();
        t_mode_off();
        t_mode_fall();
        t_mode_rise();
        t_collide();
        t_independent();
        t_reset_again();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule